// File: doc/BRIEF.md
# SPI register-access frame master

This block is an SPI master for a peripheral whose register and buffer space is reached through framed transactions. Each frame opens with a three-byte header: the 16-bit address, high byte first then low byte, and a control byte. A data phase of one or more bytes follows. The host starts a transaction with a one-cycle `req_start` pulse carrying the address, a 5-bit block select, a direction flag and a byte count. Write payload enters through a byte-wide valid/ready stream. Read payload leaves through a second one. Chip select stays low from before the first header bit until after the last payload bit, so header and payload always form one frame of any length.

The control byte carries the block select in bits [7:3], the direction in bit 2 (1 for write, 0 for read) and the operating mode in bits [1:0]. The mode is always driven as 00, meaning variable length, so the frame length is set only by how long chip select stays low. The host usually builds the block select from a socket number 0 to 7 in its upper three bits and a part code in its lower two bits (00 common, 01 socket registers, 10 transmit buffer, 11 receive buffer).

Back-pressure rules:
- **Write stream.** A byte is taken on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` rises only at a byte boundary where the next byte is payload.
- **Read stream.** `rd_valid` holds `rd_data` steady until the host raises `rd_ready`. No further read byte is shifted until the current one has gone.
- **Stalls.** While either stream is stalled, SCLK rests at its idle level and chip select stays low.

The clock is SPI mode 0 or mode 3, chosen by `cfg_idle_high`. Bit rate is the system clock divided by 2×(`cfg_div`+1).

Top module: `spi_frame_master`

## Requirements
- R1: The first three bytes of every frame on `spi_mosi` are `req_addr[15:8]`, then `req_addr[7:0]`, then the control byte {`req_block`, `req_write`, 2'b00}.
- R2: Chip select is low only while `busy` is high. It falls once and rises once per transaction. Exactly 8×(`req_len`+3) rising SCLK edges occur while it is low.
- R3: Bits go out MSB first. MISO is captured on the rising SCLK edge and MOSI changes after the falling edge. While chip select is high, SCLK rests at `cfg_idle_high` (0 is mode 0, 1 is mode 3).
- R4: In a write, the payload bytes taken from the write stream appear on MOSI after the header, in the order they were taken. Bits received during a write are dropped.
- R5: In a read, MOSI carries zero bits through the payload phase. Each payload byte captured from MISO is offered on the read stream in arrival order.
- R6: A start with `req_len` equal to 0 produces a one-cycle `req_reject` pulse on the next cycle. No frame is produced.
- R7: A start is accepted only while `busy` is low. A start pulse during a transaction has no effect on it.
- R8: `done` pulses high for one cycle, exactly one cycle after chip select returns high.
- R9: Within a byte, successive rising SCLK edges are 2×(`cfg_div`+1) cycles apart. At least `cfg_div`+1 cycles pass from chip select falling to the first SCLK edge, and from the last rising edge to chip select rising.
- R10: In a write, while the next payload byte is not valid at a byte boundary, SCLK holds its idle level and chip select stays low.
- R11: In a read, while `rd_valid` is high and `rd_ready` is low, `rd_data` stays stable and no further payload byte is shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIVW | Half-period divider; SCLK = clk / (2×(cfg_div+1)) |
| cfg_idle_high | input | 1 | 0 selects mode 0, 1 selects mode 3 |
| req_start | input | 1 | One-cycle request strobe, honoured only when not busy |
| req_addr | input | 16 | Register or buffer address |
| req_block | input | 5 | Block select placed in control bits [7:3] |
| req_write | input | 1 | 1 = write transaction, 0 = read |
| req_len | input | LENW | Payload byte count, must be at least 1 |
| busy | output | 1 | High from acceptance until the frame ends |
| done | output | 1 | One-cycle pulse one cycle after chip select rises |
| req_reject | output | 1 | One-cycle pulse for a zero-length request |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte present |
| wr_ready | output | 1 | Block takes the write byte this cycle |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | Read payload byte present |
| rd_ready | input | 1 | Host takes the read byte this cycle |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Master-out serial data |
| spi_miso | input | 1 | Master-in serial data |

## Verification
In a read, two things can fall in the same cycle at a byte boundary: the host draining the read slot and the block launching the next payload byte. The read test holds `rd_ready` high for the whole frame, so each drain lands in the cycle the next byte starts. It is judged by comparing every received byte against the bench's MISO model and by counting exactly 8×(len+3) SCLK rises. A second read test holds `rd_ready` low instead. It then confirms that the rise count freezes after the first payload byte and that `rd_data` holds.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int ADDR_W    = 16;
  localparam int BLK_W     = 5;
  localparam int HDR_BYTES = 3;
  localparam logic [1:0] OPMODE_VARLEN = 2'b00;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_BIT,
    S_GAP,
    S_HOLD,
    S_FIN
  } sfm_state_t;

  function automatic logic [7:0] ctrl_byte(input logic [BLK_W-1:0] blk, input logic wr);
    return {blk, wr, OPMODE_VARLEN};
  endfunction
endpackage

// File: rtl/sfm_halfclk.sv
module sfm_halfclk #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sfm_shifter.sv
module sfm_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       shift,
  input  logic       sample,
  input  logic       miso,
  output logic       mosi,
  output logic [7:0] rx_byte
);
  logic [7:0] tx_q;
  logic [7:0] rx_q;

  assign mosi    = tx_q[7];
  assign rx_byte = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load)       tx_q <= load_byte;
      else if (shift) tx_q <= {tx_q[6:0], 1'b0};
      if (sample)     rx_q <= {rx_q[6:0], miso};
    end
  end
endmodule

// File: rtl/sfm_rdslot.sv
module sfm_rdslot (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] push_data,
  input  logic       rd_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       free
);
  assign free = !rd_valid || rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (push)          rd_valid <= 1'b1;
      else if (rd_ready) rd_valid <= 1'b0;
      if (push)          rd_data  <= push_data;
    end
  end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import sfm_pkg::*;
#(
  parameter int DIVW = 8,
  parameter int LENW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIVW-1:0]     cfg_div,
  input  logic                cfg_idle_high,
  input  logic                req_start,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BLK_W-1:0]    req_block,
  input  logic                req_write,
  input  logic [LENW-1:0]     req_len,
  output logic                busy,
  output logic                done,
  output logic                req_reject,
  input  logic [7:0]          wr_data,
  input  logic                wr_valid,
  output logic                wr_ready,
  output logic [7:0]          rd_data,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic                spi_sclk,
  output logic                spi_cs_n,
  output logic                spi_mosi,
  input  logic                spi_miso
);
  localparam int IDXW = LENW + 1;
  localparam logic [IDXW-1:0] HDR_N = IDXW'(HDR_BYTES);

  sfm_state_t state, state_n;
  logic            half, half_n;
  logic [2:0]      bitcnt;
  logic [IDXW-1:0] idx, total, nxt_idx;
  logic [ADDR_W-1:0] lat_addr;
  logic [BLK_W-1:0]  lat_blk;
  logic            lat_wr;
  logic            cs_n_q, sclk_q, done_q, reject_q;

  logic tick, run, accept, zero_req;
  logic more, nxt_hdr, cur_rd_data, rd_free, gap_go;
  logic bit_end, byte_end, shift_en, sample_en, load_en, push_en;
  logic [7:0] hdr_byte, load_byte, rx_byte;

  assign busy       = (state != S_IDLE);
  assign done       = done_q;
  assign req_reject = reject_q;
  assign spi_cs_n   = cs_n_q;
  assign spi_sclk   = sclk_q;

  assign run      = (state == S_SETUP) || (state == S_BIT) || (state == S_HOLD);
  assign accept   = (state == S_IDLE) && req_start && (req_len != '0);
  assign zero_req = (state == S_IDLE) && req_start && (req_len == '0);

  assign nxt_idx     = idx + 1'b1;
  assign more        = (nxt_idx != total);
  assign nxt_hdr     = (nxt_idx < HDR_N);
  assign cur_rd_data = !lat_wr && (idx >= HDR_N);

  // Header bytes 1 and 2 are chosen by the low index bits; byte 0 loads at accept.
  assign hdr_byte = (nxt_idx[1:0] == 2'd1) ? lat_addr[7:0] : ctrl_byte(lat_blk, lat_wr);

  assign wr_ready = (state == S_GAP) && more && !nxt_hdr && lat_wr;
  assign gap_go   = (state == S_GAP) && more &&
                    (nxt_hdr || (lat_wr ? wr_valid : rd_free));

  assign bit_end   = (state == S_BIT) && tick && half;
  assign byte_end  = bit_end && (bitcnt == 3'd0);
  assign shift_en  = bit_end && (bitcnt != 3'd0);
  assign sample_en = (state == S_BIT) && tick && !half;
  assign push_en   = byte_end && cur_rd_data;
  assign load_en   = accept || gap_go;

  always_comb begin
    if (accept)       load_byte = req_addr[15:8];
    else if (nxt_hdr) load_byte = hdr_byte;
    else if (lat_wr)  load_byte = wr_data;
    else              load_byte = 8'h00;
  end

  always_comb begin
    state_n = state;
    half_n  = half;
    unique case (state)
      S_IDLE:  if (accept) state_n = S_SETUP;
      S_SETUP: if (tick) begin
                 state_n = S_BIT;
                 half_n  = 1'b0;
               end
      S_BIT:   if (tick) begin
                 if (!half)               half_n  = 1'b1;
                 else if (bitcnt != 3'd0) half_n  = 1'b0;
                 else                     state_n = S_GAP;
               end
      S_GAP:   if (!more) state_n = S_HOLD;
               else if (gap_go) begin
                 state_n = S_BIT;
                 half_n  = 1'b0;
               end
      S_HOLD:  if (tick) state_n = S_FIN;
      S_FIN:   state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      half     <= 1'b0;
      bitcnt   <= '0;
      idx      <= '0;
      total    <= '0;
      lat_addr <= '0;
      lat_blk  <= '0;
      lat_wr   <= 1'b0;
      cs_n_q   <= 1'b1;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      state    <= state_n;
      half     <= half_n;
      sclk_q   <= (state_n == S_BIT) ? half_n : cfg_idle_high;
      done_q   <= (state == S_FIN);
      reject_q <= zero_req;
      if (accept) begin
        lat_addr <= req_addr;
        lat_blk  <= req_block;
        lat_wr   <= req_write;
        total    <= IDXW'(req_len) + HDR_N;
        idx      <= '0;
        bitcnt   <= 3'd7;
        cs_n_q   <= 1'b0;
      end
      if (shift_en) bitcnt <= bitcnt - 1'b1;
      if (gap_go) begin
        idx    <= nxt_idx;
        bitcnt <= 3'd7;
      end
      if ((state == S_HOLD) && tick) cs_n_q <= 1'b1;
    end
  end

  sfm_halfclk #(.DIVW(DIVW)) u_halfclk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .div   (cfg_div),
    .tick  (tick)
  );

  sfm_shifter u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_en),
    .load_byte (load_byte),
    .shift     (shift_en),
    .sample    (sample_en),
    .miso      (spi_miso),
    .mosi      (spi_mosi),
    .rx_byte   (rx_byte)
  );

  sfm_rdslot u_rdslot (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_en),
    .push_data (rx_byte),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .free      (rd_free)
  );
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_idle_high,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic       busy,
  input logic       done,
  input logic       req_reject,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  p_cs_within_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);

  p_sclk_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(rst_n) && $stable(cfg_idle_high))
      |-> (spi_sclk == cfg_idle_high));

  p_reject_no_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |-> (spi_cs_n && !busy));

  p_done_after_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> done);

  p_done_cs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n);

  p_wr_stall_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> (!spi_cs_n && $stable(spi_sclk)));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind spi_frame_master sfm_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_idle_high (cfg_idle_high),
  .spi_cs_n      (spi_cs_n),
  .spi_sclk      (spi_sclk),
  .busy          (busy),
  .done          (done),
  .req_reject    (req_reject),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .rd_valid      (rd_valid),
  .rd_ready      (rd_ready),
  .rd_data       (rd_data)
);

// File: tb/sim_spi_frame_master.sv
`timescale 1ns/1ps
module sim_spi_frame_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic        cfg_idle_high = 1'b0;
  logic        req_start = 1'b0;
  logic [15:0] req_addr = '0;
  logic [4:0]  req_block = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_len = '0;
  logic        busy, done, req_reject;
  logic [7:0]  wr_data = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  always #10 clk = ~clk;

  spi_frame_master u0 (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_idle_high(cfg_idle_high),
    .req_start(req_start), .req_addr(req_addr), .req_block(req_block),
    .req_write(req_write), .req_len(req_len), .busy(busy), .done(done),
    .req_reject(req_reject), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [7:0] sbyte(input int k);
    if (k < 3) return 8'h00;
    return 8'((k * 37 + 11) & 255);
  endfunction

  function automatic logic sbit(input int n);
    logic [7:0] b;
    b = sbyte(n / 8);
    return b[7 - (n % 8)];
  endfunction

  // Monitor and peripheral model, sampled on the falling clock edge.
  bit   mon_clr = 0;
  int   cyc = 0;
  int   cs_falls, cs_rises, cs_fall_cyc, cs_rise_cyc, first_edge_cyc;
  int   rises, prev_rise_cyc, last_period, done_cnt, done_cyc, reject_cnt, rd_cnt;
  logic [7:0] mosi_sh;
  logic [7:0] mosi_bytes [0:15];
  logic [7:0] rd_bytes [0:15];
  logic prev_cs = 1'b1, prev_sclk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      cs_falls = 0; cs_rises = 0; cs_fall_cyc = 0; cs_rise_cyc = 0; first_edge_cyc = 0;
      rises = 0; prev_rise_cyc = 0; last_period = 0; done_cnt = 0; done_cyc = 0;
      reject_cnt = 0; rd_cnt = 0; mosi_sh = '0;
      for (int i = 0; i < 16; i++) begin mosi_bytes[i] = 'x; rd_bytes[i] = 'x; end
    end else begin
      if (prev_cs && !spi_cs_n) begin
        cs_falls++; cs_fall_cyc = cyc; rises = 0; first_edge_cyc = 0;
        spi_miso = sbit(0);
      end
      if (!prev_cs && spi_cs_n) begin cs_rises++; cs_rise_cyc = cyc; end
      if (!spi_cs_n && (spi_sclk != prev_sclk) && first_edge_cyc == 0) first_edge_cyc = cyc;
      if (!spi_cs_n && !prev_sclk && spi_sclk) begin
        rises++;
        mosi_sh = {mosi_sh[6:0], spi_mosi};
        if (rises % 8 == 0 && rises / 8 <= 16) mosi_bytes[rises / 8 - 1] = mosi_sh;
        if (rises % 8 != 1 && prev_rise_cyc != 0) last_period = cyc - prev_rise_cyc;
        prev_rise_cyc = cyc;
      end
      if (!spi_cs_n && prev_sclk && !spi_sclk) spi_miso = sbit(rises);
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (req_reject) reject_cnt++;
      if (rd_valid && rd_ready && rd_cnt < 16) begin rd_bytes[rd_cnt] = rd_data; rd_cnt++; end
    end
    prev_cs = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear_mon();
    mon_clr = 1; @(negedge clk); #1; mon_clr = 0;
  endtask

  task automatic start_req(input logic [15:0] a, input logic [4:0] blk,
                           input logic wr, input logic [15:0] len);
    req_addr = a; req_block = blk; req_write = wr; req_len = len;
    req_start = 1'b1; step(); req_start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (done_cnt == 0 && t < 5000) begin step(); t++; end
    repeat (4) step();
  endtask

  logic [7:0] wsrc [0:7];

  // Feeds n write bytes; before byte stall_at it waits stall cycles and checks R10 mid-stall.
  task automatic feed(input int n, input int stall_at, input int stall, input int frozen_rises);
    for (int i = 0; i < n; i++) begin
      bit hs;
      if (i == stall_at && stall > 0) begin
        int r1;
        repeat (stall / 2) step();
        r1 = rises;
        chk(spi_cs_n == 1'b0, "R10 cs low in stall", spi_cs_n, 0);
        chk(spi_sclk == cfg_idle_high, "R10 sclk idle in stall", spi_sclk, cfg_idle_high);
        repeat (stall / 2) step();
        chk(rises == r1 && rises == frozen_rises, "R10 sclk frozen", rises, frozen_rises);
      end
      wr_data = wsrc[i]; wr_valid = 1'b1;
      do begin @(negedge clk); hs = wr_ready; @(posedge clk); #1; end while (!hs);
      wr_valid = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk(spi_cs_n == 1'b1, "R2 reset cs high", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R3 reset sclk idle low", spi_sclk, 0);
    chk(busy == 1'b0 && done == 1'b0, "R8 reset not busy/done", {busy, done}, 0);
    chk(rd_valid == 1'b0, "R5 reset rd_valid low", rd_valid, 0);
  endtask

  task automatic t_write_basic();
    cfg_idle_high = 1'b0; cfg_div = 8'd1; rd_ready = 1'b1;
    wsrc[0] = 8'h81; wsrc[1] = 8'h3C;
    step(); clear_mon();
    fork
      begin start_req(16'hA55A, 5'b01101, 1'b1, 16'd2); wait_done(); end
      feed(2, -1, 0, 0);
    join
    chk(mosi_bytes[0] == 8'hA5, "R1 addr high", mosi_bytes[0], 8'hA5);
    chk(mosi_bytes[1] == 8'h5A, "R1 addr low", mosi_bytes[1], 8'h5A);
    chk(mosi_bytes[2] == 8'b01101100, "R1 control write", mosi_bytes[2], 8'b01101100);
    chk(mosi_bytes[3] == 8'h81 && mosi_bytes[4] == 8'h3C, "R4 write payload",
        {mosi_bytes[3], mosi_bytes[4]}, 16'h813C);
    chk(rises == 40, "R2 rise count", rises, 40);
    chk(cs_falls == 1 && cs_rises == 1, "R2 single frame", cs_falls * 10 + cs_rises, 11);
    chk(done_cnt == 1 && done_cyc == cs_rise_cyc + 1, "R8 done timing",
        done_cyc - cs_rise_cyc, 1);
    chk(last_period == 4, "R9 period div1", last_period, 4);
    chk(first_edge_cyc - cs_fall_cyc >= 2, "R9 setup", first_edge_cyc - cs_fall_cyc, 2);
    chk(cs_rise_cyc - prev_rise_cyc >= 2, "R9 hold", cs_rise_cyc - prev_rise_cyc, 2);
    chk(rd_cnt == 0, "R4 no read bytes in write", rd_cnt, 0);
  endtask

  task automatic t_read_mode3();
    cfg_idle_high = 1'b1; cfg_div = 8'd0; rd_ready = 1'b1;
    repeat (2) step();
    chk(spi_sclk == 1'b1, "R3 mode3 idle high", spi_sclk, 1);
    clear_mon();
    start_req(16'h0123, 5'b00011, 1'b0, 16'd3);
    wait_done();
    chk(mosi_bytes[0] == 8'h01 && mosi_bytes[1] == 8'h23, "R1 read addr",
        {mosi_bytes[0], mosi_bytes[1]}, 16'h0123);
    chk(mosi_bytes[2] == 8'b00011000, "R1 control read", mosi_bytes[2], 8'b00011000);
    for (int k = 0; k < 3; k++) begin
      chk(rd_bytes[k] == sbyte(k + 3), "R5 read byte", rd_bytes[k], sbyte(k + 3));
      chk(mosi_bytes[k + 3] == 8'h00, "R5 mosi zero", mosi_bytes[k + 3], 0);
    end
    chk(rd_cnt == 3, "R5 read count", rd_cnt, 3);
    chk(rises == 48, "R2 read rise count", rises, 48);
    chk(spi_sclk == 1'b1, "R3 mode3 idle after", spi_sclk, 1);
    chk(first_edge_cyc - cs_fall_cyc >= 1, "R9 setup div0", first_edge_cyc - cs_fall_cyc, 1);
  endtask

  task automatic t_zero_len();
    cfg_idle_high = 1'b0; step(); clear_mon();
    start_req(16'h1111, 5'b00001, 1'b1, 16'd0);
    repeat (6) step();
    chk(reject_cnt == 1, "R6 reject pulse", reject_cnt, 1);
    chk(cs_falls == 0 && busy == 1'b0, "R6 no frame", cs_falls, 0);
  endtask

  task automatic t_write_stall();
    cfg_idle_high = 1'b0; cfg_div = 8'd0;
    wsrc[0] = 8'hC3; wsrc[1] = 8'h5E;
    step(); clear_mon();
    fork
      begin start_req(16'h0F0F, 5'b10010, 1'b1, 16'd2); wait_done(); end
      feed(2, 1, 60, 32);
    join
    chk(mosi_bytes[3] == 8'hC3 && mosi_bytes[4] == 8'h5E, "R4 payload after stall",
        {mosi_bytes[3], mosi_bytes[4]}, 16'hC35E);
    chk(cs_falls == 1 && rises == 40, "R10 one frame across stall", rises, 40);
  endtask

  task automatic t_read_backpressure();
    int t = 0;
    logic [7:0] held;
    cfg_idle_high = 1'b0; cfg_div = 8'd0; rd_ready = 1'b0;
    step(); clear_mon();
    start_req(16'h2200, 5'b01011, 1'b0, 16'd3);
    while (!rd_valid && t < 2000) begin step(); t++; end
    held = rd_data;
    repeat (30) step();
    chk(rises == 32, "R11 shifting paused", rises, 32);
    chk(rd_valid && rd_data == held && held == sbyte(3), "R11 data held", rd_data, sbyte(3));
    rd_ready = 1'b1;
    wait_done();
    chk(rd_cnt == 3 && rd_bytes[1] == sbyte(4) && rd_bytes[2] == sbyte(5),
        "R11 remaining bytes", rd_cnt, 3);
  endtask

  task automatic t_busy_start();
    cfg_idle_high = 1'b0; cfg_div = 8'd2; rd_ready = 1'b1;
    wsrc[0] = 8'h96;
    step(); clear_mon();
    fork
      begin
        start_req(16'h4D2E, 5'b00101, 1'b1, 16'd1);
        repeat (20) step();
        chk(busy == 1'b1, "R7 busy mid frame", busy, 1);
        start_req(16'hFFFF, 5'b11111, 1'b0, 16'd5);
        wait_done();
      end
      feed(1, -1, 0, 0);
    join
    chk(mosi_bytes[0] == 8'h4D && mosi_bytes[1] == 8'h2E && mosi_bytes[2] == 8'b00101100,
        "R7 header unchanged", mosi_bytes[0], 8'h4D);
    chk(mosi_bytes[3] == 8'h96, "R7 payload unchanged", mosi_bytes[3], 8'h96);
    chk(rises == 32 && cs_falls == 1, "R7 no extra frame", rises, 32);
    chk(last_period == 6, "R9 period div2", last_period, 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    clear_mon();
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_write_basic();
    t_read_mode3();
    t_zero_len();
    t_write_stall();
    t_read_backpressure();
    t_busy_start();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule